// File: doc/BRIEF.md
# Multi-Mode Timer Compare Bank

This block watches a free-running timer value and compares it with a bank of software-loaded compare registers. Each channel has its own compare value and a 3-bit mode. Depending on the mode, a match raises a sticky interrupt flag, toggles the channel's pin, or sets the pin and lets the next timer overflow clear it. Two of the modes may fire only once per timer period. A channel in the first half of the bank can be paired with its partner in the second half, so that both registers toggle one shared pin.

A match counts only after the timer has changed. The timer source pulses an increment strobe or a software-write strobe in the same cycle that it presents the new value on `tmr_val`, and pulses `tmr_ovf` in the cycle that the wrapped value appears. Once a channel has fired, it stays quiet until the next timer change. All channels are evaluated in parallel, and flags and pins update on the clock edge that samples the matching timer value.

Top module: `tmr_cmp_bank`

## Requirements
- R1: After reset `irq`, `pin` and `pin_oe` are all zero, and no channel raises a flag or moves its pin until `tmr_inc` or `tmr_wr` has been seen high at least once.
- R2: Mode code 100b sets the channel flag on every match and never drives the pin. A channel in this mode can fire several times in one timer period when its compare value is rewritten.
- R3: Mode code 101b toggles the channel pin and sets its flag on every match, with `pin_oe` high.
- R4: Mode code 110b is interrupt-only and sets the flag at most once per timer period. The lockout is released by `tmr_ovf`.
- R5: Mode code 111b drives the pin to 1 on a match and to 0 on `tmr_ovf`, fires at most once per period, and keeps `pin_oe` high. A match in the same cycle as `tmr_ovf` leaves the pin at 1.
- R6: After a channel fires, it cannot fire again until the next cycle with `tmr_inc` or `tmr_wr` high. This holds even while the timer value still equals the compare value, and a `tmr_wr` pulse that presents the same value allows a new match.
- R7: Mode codes 000b to 011b disable the channel: no flag, no pin change, and `pin_oe` low.
- R8: Channel i (i < NPAIR) in mode 100b paired with channel i+NPAIR in mode 101b forms a double register. Pin i toggles on a match of either channel, and two matches in the same cycle leave it unchanged. `pin_oe[i]` is high. Pin i+NPAIR holds and its `pin_oe` is low. Both channels still set their flags.
- R9: A set flag stays set until `flag_clr` for that channel is high. A match in the same cycle as the clear leaves the flag set.
- R10: Flags and pins change on the clock edge that samples the matching timer value, one cycle after it is presented, and this holds for all channels at once.
- R11: A cycle with `wr_en` high loads channel `wr_addr`. With `wr_mode_sel` = 0 it loads the compare value from `wr_data`; with `wr_mode_sel` = 1 it loads the mode from `wr_data[2:0]`. The new value takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_val | input | TW | Current timer value |
| tmr_inc | input | 1 | Timer was incremented (new value on `tmr_val`) |
| tmr_wr | input | 1 | Timer was written by software (new value on `tmr_val`) |
| tmr_ovf | input | 1 | Timer wrapped (period boundary) |
| wr_en | input | 1 | Register write strobe |
| wr_mode_sel | input | 1 | 0: compare value, 1: mode field |
| wr_addr | input | AW | Channel index to write |
| wr_data | input | TW | Write data |
| flag_clr | input | NCH | Per-channel flag clear |
| irq | output | NCH | Sticky interrupt request flags |
| pin | output | NCH | Pin output values |
| pin_oe | output | NCH | Pin output enables |

## Verification
The bench holds the timer on a matching value without a strobe and then pulses the software-write strobe with the same value. A design that rearms on the level rather than on the timer change would fire repeatedly or not at all. It rewrites compare values within a period, so that a missing once-per-period lockout in mode 110b shows up as an extra flag and a wrongly applied lockout in mode 100b as a missing one. It places a set-on-match channel at value zero so that match and overflow coincide, where the wrong priority would leave the pin low. It also runs a paired channel with simultaneous matches, where a design that ORs rather than XORs the two events would leave the shared pin toggled.

// File: rtl/tmr_cmp_pkg.sv
// Shared mode codes and mode decoding helpers for the timer compare bank.
// Assumes a 3-bit mode field in which bit 2 enables compare.
package tmr_cmp_pkg;
    localparam logic [2:0] CM_IRQ    = 3'b100;  // flag on every match
    localparam logic [2:0] CM_TOGGLE = 3'b101;  // pin toggles on every match
    localparam logic [2:0] CM_ONCE   = 3'b110;  // flag once per period
    localparam logic [2:0] CM_SETCLR = 3'b111;  // pin set on match, cleared on overflow

    // Compare is active only for codes 100b..111b
    function automatic logic mode_active(input logic [2:0] m);
        return m[2];
    endfunction

    // Modes limited to one event per timer period
    function automatic logic mode_once(input logic [2:0] m);
        return m[2] & m[1];
    endfunction

    // Modes that own the channel's pin
    function automatic logic mode_drives(input logic [2:0] m);
        return (m == CM_TOGGLE) || (m == CM_SETCLR);
    endfunction

    // Next pin value for a channel that is not part of a double register
    function automatic logic pin_next(input logic [2:0] m, input logic ev,
                                      input logic ovf, input logic cur);
        logic r;
        r = cur;
        if (m == CM_TOGGLE)
            r = cur ^ ev;
        else if (m == CM_SETCLR)
            r = ev ? 1'b1 : (ovf ? 1'b0 : cur);
        return r;
    endfunction
endpackage

// File: rtl/tmr_cmp_chan.sv
// One compare channel: holds its compare value and mode, and detects matches.
// Assumes tmr_chg pulses in the cycle a new timer value is presented.
// Produces a single-cycle ev pulse and keeps a sticky interrupt flag.
module tmr_cmp_chan
    import tmr_cmp_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_cmp,
    input  logic          ld_mode,
    input  logic [TW-1:0] wr_data,
    input  logic [TW-1:0] tmr_val,
    input  logic          tmr_chg,
    input  logic          tmr_ovf,
    input  logic          flag_clr,
    output logic          ev,
    output logic [2:0]    mode,
    output logic          irq
);
    logic [TW-1:0] cmp_q;
    logic [2:0]    mode_q;
    logic          armed_q, lock_q, irq_q;
    logic          arm, lock_eff;

    // Match detection: armed by a timer change, gated by the period lockout
    always_comb begin
        arm      = armed_q | tmr_chg;
        lock_eff = lock_q & ~tmr_ovf;
        ev       = mode_active(mode_q) & arm & (cmp_q == tmr_val) & ~lock_eff;
    end

    // Register file, arming, lockout and sticky flag state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q   <= '0;
            mode_q  <= '0;
            armed_q <= 1'b0;
            lock_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (ld_cmp)  cmp_q  <= wr_data;
            if (ld_mode) mode_q <= wr_data[2:0];
            armed_q <= arm & ~ev;
            lock_q  <= lock_eff | (ev & mode_once(mode_q));
            irq_q   <= ev | (irq_q & ~flag_clr);
        end
    end

    assign mode = mode_q;
    assign irq  = irq_q;
endmodule

// File: rtl/tmr_cmp_pair.sv
// Pin logic for one channel pair (first-bank channel a, second-bank channel b).
// When a is in CM_IRQ and b is in CM_TOGGLE, both events toggle pin a.
module tmr_cmp_pair
    import tmr_cmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_a,
    input  logic [2:0] mode_b,
    input  logic       ev_a,
    input  logic       ev_b,
    input  logic       tmr_ovf,
    output logic       pin_a,
    output logic       pin_b,
    output logic       oe_a,
    output logic       oe_b
);
    logic dbl;
    logic pa_q, pb_q;

    // Double-register detection and output enables
    always_comb begin
        dbl  = (mode_a == CM_IRQ) && (mode_b == CM_TOGGLE);
        oe_a = dbl | mode_drives(mode_a);
        oe_b = ~dbl & mode_drives(mode_b);
    end

    // Pin state update for both channels of the pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_q <= 1'b0;
            pb_q <= 1'b0;
        end else if (dbl) begin
            pa_q <= pa_q ^ ev_a ^ ev_b;
        end else begin
            pa_q <= pin_next(mode_a, ev_a, tmr_ovf, pa_q);
            pb_q <= pin_next(mode_b, ev_b, tmr_ovf, pb_q);
        end
    end

    assign pin_a = pa_q;
    assign pin_b = pb_q;
endmodule

// File: rtl/tmr_cmp_bank.sv
// Bank of 2*NPAIR compare channels on one free-running timer.
// Channel i is paired with channel i+NPAIR for the double-register mode.
// Assumes tmr_inc/tmr_wr/tmr_ovf arrive together with the new tmr_val.
module tmr_cmp_bank
    import tmr_cmp_pkg::*;
#(
    parameter int TW    = 8,
    parameter int NPAIR = 4,
    localparam int NCH  = 2 * NPAIR,
    localparam int AW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TW-1:0]  tmr_val,
    input  logic           tmr_inc,
    input  logic           tmr_wr,
    input  logic           tmr_ovf,
    input  logic           wr_en,
    input  logic           wr_mode_sel,
    input  logic [AW-1:0]  wr_addr,
    input  logic [TW-1:0]  wr_data,
    input  logic [NCH-1:0] flag_clr,
    output logic [NCH-1:0] irq,
    output logic [NCH-1:0] pin,
    output logic [NCH-1:0] pin_oe
);
    logic [NCH-1:0] ev_vec;
    logic [2:0]     mode_vec [NCH];
    logic           tmr_chg;

    assign tmr_chg = tmr_inc | tmr_wr;

    // Per-channel compare state
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic sel;
        assign sel = wr_en && (wr_addr == AW'(c));
        tmr_cmp_chan #(.TW(TW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_cmp   (sel & ~wr_mode_sel),
            .ld_mode  (sel & wr_mode_sel),
            .wr_data  (wr_data),
            .tmr_val  (tmr_val),
            .tmr_chg  (tmr_chg),
            .tmr_ovf  (tmr_ovf),
            .flag_clr (flag_clr[c]),
            .ev       (ev_vec[c]),
            .mode     (mode_vec[c]),
            .irq      (irq[c])
        );
    end

    // Pin logic, one instance per first/second-bank pair
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        tmr_cmp_pair u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode_a  (mode_vec[p]),
            .mode_b  (mode_vec[p+NPAIR]),
            .ev_a    (ev_vec[p]),
            .ev_b    (ev_vec[p+NPAIR]),
            .tmr_ovf (tmr_ovf),
            .pin_a   (pin[p]),
            .pin_b   (pin[p+NPAIR]),
            .oe_a    (pin_oe[p]),
            .oe_b    (pin_oe[p+NPAIR])
        );
    end
endmodule

// File: rtl/tmr_cmp_bank_chk.sv
// Property checker for tmr_cmp_bank, attached through bind.
module tmr_cmp_bank_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tmr_inc,
    input logic           tmr_wr,
    input logic           tmr_ovf,
    input logic [NCH-1:0] flag_clr,
    input logic [NCH-1:0] irq,
    input logic [NCH-1:0] pin,
    input logic [NCH-1:0] pin_oe,
    input logic [NCH-1:0] ev
);
    logic seen_chg;

    // Tracks whether any timer change has happened since reset
    always_ff @(posedge clk) begin
        if (!rst_n) seen_chg <= 1'b0;
        else if (tmr_inc | tmr_wr) seen_chg <= 1'b1;
    end

    p_quiet_until_change_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_chg |-> (irq == '0));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(irq) & ~$past(flag_clr) & ~irq) == '0));

    p_no_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((ev & $past(ev)) == '0) || tmr_inc || tmr_wr));

    p_pin_hold_oe_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pin ^ $past(pin)) & ~$past(pin_oe)) == '0));

    p_pin_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pin == $past(pin)) || ($past(ev) != '0) || $past(tmr_ovf)));
endmodule

bind tmr_cmp_bank tmr_cmp_bank_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr_inc  (tmr_inc),
    .tmr_wr   (tmr_wr),
    .tmr_ovf  (tmr_ovf),
    .flag_clr (flag_clr),
    .irq      (irq),
    .pin      (pin),
    .pin_oe   (pin_oe),
    .ev       (ev_vec)
);

// File: tb/tmr_cmp_bank_bench.sv
// Self-checking bench: behavioural reference model compared every clock,
// plus directed checks against hand-derived values.
module tmr_cmp_bank_bench;
    localparam int TW = 8;
    localparam int NP = 4;
    localparam int NCH = 2 * NP;
    localparam int AW = $clog2(NCH);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [TW-1:0]  tmr_val = '0;
    logic           tmr_inc = 1'b0, tmr_wr = 1'b0, tmr_ovf = 1'b0;
    logic           wr_en = 1'b0, wr_mode_sel = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [TW-1:0]  wr_data = '0;
    logic [NCH-1:0] flag_clr = '0;
    logic [NCH-1:0] irq, pin, pin_oe;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    int m_cmp [NCH];
    int m_mode [NCH];
    bit m_arm [NCH], m_lock [NCH], m_irq [NCH], m_pin [NCH];

    always #5 clk = ~clk;

    tmr_cmp_bank #(.TW(TW), .NPAIR(NP)) u_tmr_cmp_bank (
        .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val), .tmr_inc(tmr_inc),
        .tmr_wr(tmr_wr), .tmr_ovf(tmr_ovf), .wr_en(wr_en),
        .wr_mode_sel(wr_mode_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .flag_clr(flag_clr), .irq(irq), .pin(pin), .pin_oe(pin_oe)
    );

    task automatic check(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_oe(input int c);
        int a = (c < NP) ? c : c - NP;
        bit dbl = (m_mode[a] == 4) && (m_mode[a+NP] == 5);
        if (c < NP) return dbl || m_mode[c] == 5 || m_mode[c] == 7;
        return !dbl && (m_mode[c] == 5 || m_mode[c] == 7);
    endfunction

    function automatic bit pin_rule(input int md, input bit e, input bit cur);
        if (md == 5) return cur ^ e;
        if (md == 7) return e ? 1'b1 : (tmr_ovf ? 1'b0 : cur);
        return cur;
    endfunction

    // One clock: model next state from current inputs, then compare outputs
    task automatic tick();
        bit ev [NCH];
        bit n_arm [NCH], n_lock [NCH], n_irq [NCH], n_pin [NCH];
        bit chg = tmr_inc | tmr_wr;
        int ex_irq = 0, ex_pin = 0, ex_oe = 0;
        for (int c = 0; c < NCH; c++) begin
            bit a = m_arm[c] | chg;
            bit lk = m_lock[c] && !tmr_ovf;
            ev[c] = (m_mode[c] >= 4) && a && (m_cmp[c] == int'(tmr_val)) && !lk;
            n_arm[c] = a && !ev[c];
            n_lock[c] = lk || (ev[c] && m_mode[c] >= 6);
            n_irq[c] = ev[c] || (m_irq[c] && !flag_clr[c]);
        end
        for (int p = 0; p < NP; p++) begin
            if (m_mode[p] == 4 && m_mode[p+NP] == 5) begin
                n_pin[p] = m_pin[p] ^ ev[p] ^ ev[p+NP];
                n_pin[p+NP] = m_pin[p+NP];
            end else begin
                n_pin[p] = pin_rule(m_mode[p], ev[p], m_pin[p]);
                n_pin[p+NP] = pin_rule(m_mode[p+NP], ev[p+NP], m_pin[p+NP]);
            end
        end
        if (wr_en) begin
            if (wr_mode_sel) m_mode[wr_addr] = int'(wr_data[2:0]);
            else m_cmp[wr_addr] = int'(wr_data);
        end
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            m_arm[c] = n_arm[c]; m_lock[c] = n_lock[c];
            m_irq[c] = n_irq[c]; m_pin[c] = n_pin[c];
            ex_irq |= int'(m_irq[c]) << c;
            ex_pin |= int'(m_pin[c]) << c;
            ex_oe  |= int'(m_oe(c)) << c;
        end
        check(int'(irq), ex_irq, "R2 model irq");
        check(int'(pin), ex_pin, "R3 model pin");
        check(int'(pin_oe), ex_oe, "R8 model oe");
    endtask

    task automatic wr(input int ch, input bit is_mode, input int d);
        wr_en = 1'b1; wr_mode_sel = is_mode; wr_addr = AW'(ch); wr_data = TW'(d);
        tick();
        wr_en = 1'b0; wr_mode_sel = 1'b0;
    endtask

    task automatic tstep();
        tmr_val = tmr_val + 1'b1;
        tmr_inc = 1'b1;
        tmr_ovf = (tmr_val == '0);
        tick();
        tmr_inc = 1'b0; tmr_ovf = 1'b0;
    endtask

    task automatic run_to(input int v);
        while (int'(tmr_val) != v) tstep();
    endtask

    task automatic clear(input int mask);
        flag_clr = NCH'(mask);
        tick();
        flag_clr = '0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_cmp[c] = 0; m_mode[c] = 0; m_arm[c] = 0;
            m_lock[c] = 0; m_irq[c] = 0; m_pin[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(irq), 0, "R1 reset irq");
        check(int'(pin), 0, "R1 reset pin");
        check(int'(pin_oe), 0, "R1 reset oe");

        // R11: load compare values and modes
        wr(0, 0, 5); wr(0, 1, 4);
        wr(1, 0, 6); wr(1, 1, 5);
        wr(2, 0, 7); wr(2, 1, 6);
        wr(3, 0, 8); wr(3, 1, 7);
        wr(5, 0, 5); wr(5, 1, 2);
        check(int'(pin_oe), 'h0A, "R3 R5 R7 oe after mode writes");

        // R1: timer sits on a match value without any change strobe
        tmr_val = 8'd5;
        repeat (3) tick();
        check(int'(irq), 0, "R1 no event before timer change");

        tstep();  // 6
        check(int'(irq[1]), 1, "R10 R11 mode1 flag one cycle after match");
        check(int'(pin[1]), 1, "R3 mode1 toggle");
        tstep();  // 7
        check(int'(irq[2]), 1, "R4 mode2 first flag");
        tstep();  // 8
        check(int'(pin[3]), 1, "R5 mode3 set on match");

        wr(0, 0, 9);
        tstep();  // 9
        check(int'(irq[0]), 1, "R2 mode0 flag");
        check(int'(pin[0]), 0, "R2 mode0 pin untouched");
        clear(1);
        check(int'(irq[0]), 0, "R9 flag cleared");
        repeat (2) tick();
        check(int'(irq[0]), 0, "R6 no repeat while timer static");
        tmr_wr = 1'b1; tick(); tmr_wr = 1'b0;
        check(int'(irq[0]), 1, "R6 timer write rearms");

        clear('h05);
        wr(0, 0, 20); wr(2, 0, 15);
        run_to(20);
        check(int'(irq[2]), 0, "R4 mode2 locked within period");
        check(int'(irq[0]), 1, "R2 mode0 second event in period");

        run_to(255);
        clear('hFF);
        tstep();  // 0 with overflow
        check(int'(pin[3]), 0, "R5 mode3 cleared on overflow");

        run_to(5);
        flag_clr = 8'h02; tstep(); flag_clr = '0;  // 6, match with clear
        check(int'(irq[1]), 1, "R9 set wins over clear");
        check(int'(pin[1]), 0, "R3 mode1 toggles back");
        run_to(15);
        check(int'(irq[2]), 1, "R4 lockout released by overflow");
        check(int'(pin[3]), 1, "R5 mode3 set again next period");
        check(int'(irq[5]), 0, "R7 disabled channel no flag");
        check(int'(pin[5]), 0, "R7 disabled channel no pin");

        wr(3, 0, 0);
        run_to(255);
        tstep();  // 0: match and overflow together
        check(int'(pin[3]), 1, "R5 match wins over overflow");

        // R8: double-register pair (0,4)
        wr(0, 0, 25); wr(4, 0, 30); wr(4, 1, 5);
        check(int'(pin_oe[0]), 1, "R8 first-bank oe on");
        check(int'(pin_oe[4]), 0, "R8 second-bank oe off");
        clear('hFF);
        run_to(25);
        check(int'(pin[0]), 1, "R8 toggle by first register");
        run_to(30);
        check(int'(pin[0]), 0, "R8 toggle by second register");
        check(int'(pin[4]), 0, "R8 second-bank pin held");
        check(int'(irq[4]), 1, "R8 second-bank flag");
        wr(0, 0, 40); wr(4, 0, 40);
        clear('hFF);
        run_to(40);
        check(int'(pin[0]), 0, "R8 simultaneous matches cancel");
        check(int'(irq[0] & irq[4]), 1, "R8 both flags on simultaneous match");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule